// File: doc/BRIEF.md
# Serial Time-Frame Access Port

This block is the serial slave that sits between a host and a timekeeping counter. The host uses four pad signals: an enable, a direction select, a shift clock and one data line. The block moves a 52-bit time and calendar frame across that line, least significant bit first. Every pad input passes through a synchronizer into the fast system clock. Edges of the enable and of the shift clock are detected in that domain. The data pad is driven through a separate output value and output enable, and the pad cell itself sits outside the block.

A read takes a snapshot of the counter frame on the first rising shift clock and streams it out. The host may stop the read early by lowering the enable. A write collects the frame bit by bit and hands it to the counter as a one-cycle load, but only once all 52 bits have arrived. While a write is in progress, the block asks the counter to stop advancing and to clear its sub-second prescaler.

The block also owns two flag bits that travel inside the frame. One is a supply-fail flag, raised by a supply-low level input. The other is a test bit, which only lives while the enable is high.

Top module: `rtc_serial_port`

## Requirements
- R1: After reset the data output enable, hold, load strobe, prescaler clear, supply-fail flag and test bit are all 0.
- R2: In read mode (enable high, direction low), the frame on `time_i` is captured at the first rising shift clock. Bit k of the frame appears on `sdata_o` after rising edge k+1. Bit 7 is replaced by the supply-fail flag and bit 43 by the test bit. Changes to `time_i` after the capture do not alter the read.
- R3: A read may stop after any number of bits, and the bits sent so far are correct. Rising edges beyond the 52nd leave `sdata_o` holding frame bit 51, and the internal bit count never exceeds 52.
- R4: `sdata_oe_o` is high only while the enable is high and the direction input is low.
- R5: In write mode (enable high, direction high), serial bits are collected LSB first. The 52nd rising edge produces exactly one single-cycle `load_o` pulse, with `load_frame_o` equal to the 52 bits. Bits after the 52nd are ignored.
- R6: A write that ends (enable low) before 52 bits produces no `load_o`.
- R7: `hold_o` rises on the first falling shift clock of a write. It stays high after the enable falls, whether or not the write completed, and it clears on the next rising edge of the enable.
- R8: `prescale_clr_o` is high between the first and second rising shift clocks of a write and low otherwise.
- R9: The supply-fail flag is set while `supply_low_i` is high. It is cleared only when a read of 48 or more bits ends. A read of 47 or fewer bits, or any write, leaves it set.
- R10: A completed write copies frame bit 43 into the test bit, which is forced to 0 whenever the enable is low.
- R11: With the enable low, shift clock, direction and data activity causes no load, no hold and no output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Transfer enable pad, asynchronous |
| wr_i | input | 1 | Direction pad: 1 write, 0 read |
| sclk_i | input | 1 | Shift clock pad |
| sdata_i | input | 1 | Serial data from pad |
| sdata_o | output | 1 | Serial data to pad |
| sdata_oe_o | output | 1 | Pad drive enable for sdata_o |
| supply_low_i | input | 1 | Supply-low level from detector |
| time_i | input | 52 | Current counter frame |
| load_o | output | 1 | One-cycle commit strobe to counter |
| load_frame_o | output | 52 | Frame to commit |
| hold_o | output | 1 | Counter advance hold |
| prescale_clr_o | output | 1 | Sub-second prescaler clear |
| fail_flag_o | output | 1 | Supply-fail flag |
| test_bit_o | output | 1 | Test bit |

## Verification
A wrong bit count shows up quickly at the ports. A read streams a shifted or truncated frame within one shift clock of the error, and a write commits early, late or never at its 52nd edge. A stuck mode or edge register shows up as an output enable during writes or as a hold that never releases at the next enable rise. A faulty flag path is exposed by the 47-bit and 48-bit reads that bracket the clear threshold, since the flag is observed both in the streamed bit 7 and on its own output.

// File: rtl/rtc_ser_pkg.sv
package rtc_ser_pkg;
    localparam int N_PINS  = 5;
    localparam int PIN_CE  = 0;
    localparam int PIN_WR  = 1;
    localparam int PIN_SCK = 2;
    localparam int PIN_SDI = 3;
    localparam int PIN_LOW = 4;
    localparam int EDGE_CE  = 0;
    localparam int EDGE_SCK = 1;
endpackage

// File: rtl/rtc_ser_sync.sv
module rtc_ser_sync #(
    parameter int N      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] lvl_o
);
    logic [STAGES-1:0][N-1:0] stg_d, stg_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb stg_d = async_i;
        end else begin : g_many
            always_comb stg_d = {stg_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign lvl_o = stg_q[STAGES-1];
endmodule

// File: rtl/rtc_ser_edge.sv
module rtc_ser_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
        rise_o = lvl_i & ~prev_q;
        fall_o = ~lvl_i & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/rtc_ser_shift.sv
module rtc_ser_shift #(
    parameter int W    = 52,
    parameter int CW   = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          capture_i,
    input  logic          shift_i,
    input  logic          ser_i,
    input  logic [W-1:0]  par_i,
    output logic [W-1:0]  sh_o,
    output logic [CW-1:0] cnt_o
);
    typedef struct packed {
        logic [W-1:0]  sh;
        logic [CW-1:0] cnt;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            s_d.cnt = '0;
        end else if (capture_i) begin
            s_d.sh  = par_i;
            s_d.cnt = CW'(1);
        end else if (shift_i) begin
            s_d.sh  = {ser_i, s_q.sh[W-1:1]};
            s_d.cnt = s_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sh_o  = s_q.sh;
    assign cnt_o = s_q.cnt;
endmodule

// File: rtl/rtc_serial_port.sv
module rtc_serial_port
    import rtc_ser_pkg::*;
#(
    parameter int FRAME_W     = 52,
    parameter int FLAG_POS    = 7,
    parameter int TEST_POS    = 43,
    parameter int CLEAR_MIN   = 48,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ce_i,
    input  logic               wr_i,
    input  logic               sclk_i,
    input  logic               sdata_i,
    output logic               sdata_o,
    output logic               sdata_oe_o,
    input  logic               supply_low_i,
    input  logic [FRAME_W-1:0] time_i,
    output logic               load_o,
    output logic [FRAME_W-1:0] load_frame_o,
    output logic               hold_o,
    output logic               prescale_clr_o,
    output logic               fail_flag_o,
    output logic               test_bit_o
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] CNT_CLEAR = CNT_W'(CLEAR_MIN);

    typedef struct packed {
        logic               hold;
        logic               prclr;
        logic               load;
        logic [FRAME_W-1:0] frame;
        logic               flag;
        logic               test;
        logic               oe;
        logic               wmode;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [N_PINS-1:0] pins, lvl;
    logic [1:0]        edge_lvl, rise, fall;
    logic              ce_s, wr_s, sdi_s, low_s;
    logic              ce_rise, ce_fall, sck_rise, sck_fall;
    logic [FRAME_W-1:0] sh, snap;
    logic [CNT_W-1:0]   cnt;
    logic               read_edge, write_edge, cnt_zero, cnt_full;
    logic               capture, shift_en, shift_in;

    always_comb begin
        pins          = '0;
        pins[PIN_CE]  = ce_i;
        pins[PIN_WR]  = wr_i;
        pins[PIN_SCK] = sclk_i;
        pins[PIN_SDI] = sdata_i;
        pins[PIN_LOW] = supply_low_i;
    end

    rtc_ser_sync #(.N(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pins),
        .lvl_o  (lvl)
    );

    always_comb begin
        edge_lvl           = '0;
        edge_lvl[EDGE_CE]  = lvl[PIN_CE];
        edge_lvl[EDGE_SCK] = lvl[PIN_SCK];
    end

    rtc_ser_edge #(.N(2)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (edge_lvl),
        .rise_o(rise),
        .fall_o(fall)
    );

    assign ce_s     = lvl[PIN_CE];
    assign wr_s     = lvl[PIN_WR];
    assign sdi_s    = lvl[PIN_SDI];
    assign low_s    = lvl[PIN_LOW];
    assign ce_rise  = rise[EDGE_CE];
    assign ce_fall  = fall[EDGE_CE];
    assign sck_rise = rise[EDGE_SCK];
    assign sck_fall = fall[EDGE_SCK];

    // Transfer control: mode qualified shift clock edges and bit count state
    always_comb begin
        read_edge  = ce_s & ~wr_s & sck_rise;
        write_edge = ce_s &  wr_s & sck_rise;
        cnt_zero   = (cnt == '0);
        cnt_full   = (cnt == CNT_FULL);
        capture    = read_edge & cnt_zero;
        shift_en   = (read_edge & ~cnt_zero & ~cnt_full) | (write_edge & ~cnt_full);
        shift_in   = sdi_s & wr_s;
        snap           = time_i;
        snap[FLAG_POS] = c_q.flag;
        snap[TEST_POS] = c_q.test;
    end

    rtc_ser_shift #(.W(FRAME_W), .CW(CNT_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (~ce_s),
        .capture_i(capture),
        .shift_i  (shift_en),
        .ser_i    (shift_in),
        .par_i    (snap),
        .sh_o     (sh),
        .cnt_o    (cnt)
    );

    always_comb begin
        c_d      = c_q;
        c_d.load = 1'b0;
        c_d.oe   = ce_s & ~wr_s;
        if (ce_s) c_d.wmode = wr_s;

        if (ce_rise)                        c_d.hold = 1'b0;
        else if (ce_s & wr_s & sck_fall)    c_d.hold = 1'b1;

        c_d.prclr = ce_s & wr_s & (cnt == CNT_W'(1));

        if (write_edge && cnt == CNT_LAST) begin
            c_d.load  = 1'b1;
            c_d.frame = {sdi_s, sh[FRAME_W-1:1]};
        end

        if (low_s)
            c_d.flag = 1'b1;
        else if (ce_fall && !c_q.wmode && cnt >= CNT_CLEAR)
            c_d.flag = 1'b0;

        if (!ce_s)        c_d.test = 1'b0;
        else if (c_d.load) c_d.test = c_d.frame[TEST_POS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign sdata_o        = sh[0];
    assign sdata_oe_o     = c_q.oe;
    assign load_o         = c_q.load;
    assign load_frame_o   = c_q.frame;
    assign hold_o         = c_q.hold;
    assign prescale_clr_o = c_q.prclr;
    assign fail_flag_o    = c_q.flag;
    assign test_bit_o     = c_q.test;
endmodule

// File: rtl/rtc_ser_chk.sv
module rtc_ser_chk #(
    parameter int FRAME_W = 52,
    parameter int CNT_W   = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce_s,
    input logic             wr_s,
    input logic             ce_rise,
    input logic             low_s,
    input logic [CNT_W-1:0] cnt,
    input logic             load,
    input logic             hold,
    input logic             oe,
    input logic             flag,
    input logic             test
);
    a_r3_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(FRAME_W));

    a_r5_load_at_full: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> cnt == CNT_W'(FRAME_W));

    a_r5_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);

    a_r7_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
        ce_rise |=> !hold);

    a_r4_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> ($past(ce_s) && !$past(wr_s)));

    a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        low_s |=> flag);

    a_r10_test_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_s |=> !test);

    a_r11_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_s |=> cnt == '0);
endmodule

bind rtc_serial_port rtc_ser_chk #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_s   (ce_s),
    .wr_s   (wr_s),
    .ce_rise(ce_rise),
    .low_s  (low_s),
    .cnt    (cnt),
    .load   (load_o),
    .hold   (hold_o),
    .oe     (sdata_oe_o),
    .flag   (fail_flag_o),
    .test   (test_bit_o)
);

// File: tb/sim_rtc_serial_port.sv
`timescale 1ns/1ps
module sim_rtc_serial_port;
    localparam int FW = 52;
    localparam int H  = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce = 1'b0, wr = 1'b0, sck = 1'b0, sdi = 1'b0, low = 1'b0;
    logic [FW-1:0] cur = '0;
    logic sdo, oe, load, hold, prclr, flag, test;
    logic [FW-1:0] lf;

    int n_chk = 0, n_fail = 0, n_load = 0;
    logic [FW-1:0] last_load = '0;
    logic flag_exp = 1'b0;
    logic [63:0] got;
    bit b;

    always #2.5 clk = ~clk;

    rtc_serial_port u0 (
        .clk(clk), .rst_n(rst_n), .ce_i(ce), .wr_i(wr), .sclk_i(sck),
        .sdata_i(sdi), .sdata_o(sdo), .sdata_oe_o(oe), .supply_low_i(low),
        .time_i(cur), .load_o(load), .load_frame_o(lf), .hold_o(hold),
        .prescale_clr_o(prclr), .fail_flag_o(flag), .test_bit_o(test)
    );

    always @(negedge clk) if (rst_n && load) begin
        n_load    = n_load + 1;
        last_load = lf;
    end

    task automatic wt(int n); repeat (n) @(negedge clk); endtask

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic start(bit w); wr = w; wt(H); ce = 1'b1; wt(H); endtask
    task automatic stop(); ce = 1'b0; wt(H); endtask

    task automatic pulse(bit d, output bit q);
        sdi = d; wt(2);
        sck = 1'b1; wt(H);
        q = sdo;
        sck = 1'b0; wt(H);
    endtask

    task automatic rd(int n, output logic [63:0] r);
        bit q;
        r = '0;
        start(1'b0);
        for (int i = 0; i < n; i++) begin
            pulse(1'b0, q);
            if (i < 64) r[i] = q;
        end
        stop();
    endtask

    task automatic wrt(logic [FW-1:0] f, int n);
        bit q;
        start(1'b1);
        for (int i = 0; i < n; i++) pulse((i < FW) ? f[i] : 1'($urandom), q);
        stop();
    endtask

    function automatic logic [FW-1:0] exp_frame(logic [FW-1:0] t, logic fl);
        logic [FW-1:0] e = t;
        e[7]  = fl;
        e[43] = 1'b0;
        return e;
    endfunction

    function automatic logic [FW-1:0] rnd52();
        return {20'($urandom), 32'($urandom)};
    endfunction

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [FW-1:0] f, e;
        int l0;
        int unsigned seed_v;
        seed_v = $urandom(32'd4242);
        wt(5); rst_n = 1'b1; wt(3);
        // R1 reset state
        chk({oe, hold, load, prclr, flag, test} == 6'b0, "R1 reset outputs",
            {58'd0, oe, hold, load, prclr, flag, test}, 64'd0);

        // R4 output enable follows mode
        start(1'b0);
        chk(oe == 1'b1, "R4 oe in read", oe, 1);
        wr = 1'b1; wt(H);
        chk(oe == 1'b0, "R4 oe off in write", oe, 0);
        stop();
        chk(oe == 1'b0, "R4 oe off idle", oe, 0);

        // R2 random full reads
        for (int k = 0; k < 4; k++) begin
            cur = rnd52();
            rd(FW, got);
            e = exp_frame(cur, flag_exp);
            chk(got[FW-1:0] == e, "R2 full read", 64'(got[FW-1:0]), 64'(e));
        end

        // R2 snapshot taken at first edge
        cur = rnd52(); e = exp_frame(cur, flag_exp); got = '0;
        start(1'b0);
        for (int i = 0; i < FW; i++) begin
            pulse(1'b0, b); got[i] = b;
            if (i == 0) cur = ~cur;
        end
        stop();
        chk(got[FW-1:0] == e, "R2 snapshot", 64'(got[FW-1:0]), 64'(e));

        // R3 overrun and partial reads
        for (int k = 0; k < 2; k++) begin
            cur = rnd52(); cur[51] = k[0];
            e = exp_frame(cur, flag_exp);
            rd(60, got);
            chk(got[FW-1:0] == e, "R3 overrun body", 64'(got[FW-1:0]), 64'(e));
            chk(got[59:52] == {8{e[51]}}, "R3 overrun tail", 64'(got[59:52]), 64'({8{e[51]}}));
        end
        cur = rnd52(); e = exp_frame(cur, flag_exp);
        rd(28, got);
        chk(got[27:0] == e[27:0], "R3 partial 28", 64'(got[27:0]), 64'(e[27:0]));

        // R9 flag set, short read keeps it, write keeps it, 48-bit read clears
        low = 1'b1; wt(4); low = 1'b0; wt(H); flag_exp = 1'b1;
        chk(flag == 1'b1, "R9 flag set", flag, 1);
        cur = rnd52();
        rd(47, got);
        chk(got[7] == 1'b1, "R9 flag in frame", got[7], 1);
        chk(flag == 1'b1, "R9 flag kept after 47", flag, 1);
        wrt(rnd52(), FW);
        chk(flag == 1'b1, "R9 flag kept after write", flag, 1);
        rd(48, got);
        flag_exp = 1'b0;
        chk(flag == 1'b0, "R9 flag cleared after 48", flag, 0);

        // R5 writes with extra bits
        for (int k = 0; k < 4; k++) begin
            f = rnd52(); l0 = n_load;
            wrt(f, FW + k * 3);
            chk(n_load == l0 + 1, "R5 one load", 64'(n_load - l0), 64'd1);
            chk(last_load == f, "R5 load frame", 64'(last_load), 64'(f));
        end

        // R10 test bit from a completed write, cleared when enable drops
        f = rnd52(); f[43] = 1'b1;
        start(1'b1);
        for (int i = 0; i < FW; i++) pulse(f[i], b);
        wt(H);
        chk(test == 1'b1, "R10 test set", test, 1);
        stop();
        chk(test == 1'b0, "R10 test cleared", test, 0);

        // R7 R8 R6 short write with hold and prescaler clear
        l0 = n_load;
        start(1'b1);
        chk(hold == 1'b0, "R7 hold cleared on enable rise", hold, 0);
        sdi = 1'b1; wt(2); sck = 1'b1; wt(H);
        chk(prclr == 1'b1, "R8 prescale clear after first edge", prclr, 1);
        chk(hold == 1'b0, "R7 no hold before falling edge", hold, 0);
        sck = 1'b0; wt(H);
        chk(hold == 1'b1, "R7 hold after first fall", hold, 1);
        sdi = 1'b0; wt(2); sck = 1'b1; wt(H);
        chk(prclr == 1'b0, "R8 prescale clear ends", prclr, 0);
        sck = 1'b0; wt(H);
        for (int i = 0; i < 8; i++) pulse(1'($urandom), b);
        stop();
        chk(hold == 1'b1, "R7 hold persists after discard", hold, 1);
        chk(n_load == l0, "R6 short write discarded", 64'(n_load - l0), 64'd0);
        start(1'b0);
        chk(hold == 1'b0, "R7 hold released", hold, 0);
        stop();

        // R11 activity with enable low
        l0 = n_load; wr = 1'b1;
        for (int i = 0; i < 60; i++) begin
            sdi = 1'($urandom); wt(2); sck = 1'b1; wt(3); sck = 1'b0; wt(3);
            if (i == 30) wr = 1'b0;
        end
        chk(n_load == l0, "R11 no load idle", 64'(n_load - l0), 64'd0);
        chk(hold == 1'b0, "R11 no hold idle", hold, 0);
        chk(oe == 1'b0, "R11 no oe idle", oe, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule